// File: doc/BRIEF.md
# Slave Response Frame Decoder

This block sits on the monitoring side of a two-wire serial management link: one clock line and one active-low data line. The command-side logic pulses `cmd_end` when a master command frame has finished. It also supplies the addressed slave, whether the command was a read, the requested data size and whether it was an interrupt poll. From that pulse on, this block owns the line until the slave's reply has been decoded.

The link clock and data line are brought into the system clock domain through synchronisers. The slave drives bits that are valid at the falling edge of the link clock, so only falling edges form bit slots. After a fixed turnaround, the block hunts for the slave's start bit, with a bounded wait. It then parses the frame in this order:

- the slave ID;
- a response code whose length depends on the pending command;
- optional payload fields;
- a 4-bit check code.

When the frame ends, the block publishes the decoded reply and a one-cycle completion pulse. It also keeps a running count of consecutive busy replies from the addressed slave.

Top module: `slv_rsp_decoder`

## Requirements
- R1: After reset, `done` and `timeout` are 0, `busy_count` is 0 and `rsp_kind` is 0 (none).
- R2: A bit slot is a falling edge of `lnk_clk`, and the bit value is the inverse of `lnk_line` at that edge (line low means 1). The line level at rising edges has no effect.
- R3: After `cmd_end`, the first 3 slots are turnaround slots, and a 1 in them is not taken as a start bit.
- R4: The 256 slots after the turnaround are searched for a start bit (a 1), and a start in the 256th slot is accepted. If all 256 slots are 0, `timeout` pulses for one cycle, no `done` follows, and the block ignores the line until the next `cmd_end`.
- R5: The slave ID is 2 bits, sent LSB first, and is published on `rsp_slave`. `id_mismatch` is 1 when it differs from `cmd_slave`.
- R6: A 2-bit response code is sent MSB first and maps to `rsp_kind` as follows:
  - 00 gives 1 (acknowledge), or 2 (acknowledge with data) when `cmd_read` is 1;
  - 01 gives 3 (busy);
  - 10 gives 4 (address error);
  - 11 gives 5 (check error).
- R7: After an acknowledge with data, 8, 16 or 32 data bits follow, MSB first. `cmd_size` 0, 1 and 2 select those lengths, and 3 is treated as 32. The data is right-aligned on `rsp_data`, which is 0 for any other reply.
- R8: If `cmd_ipoll` is 1 and the ID matches, a single first code bit of 0 is an interrupt-poll reply (`rsp_kind` 6). It is followed by a 2-bit interrupt field and then a 3-bit DMA control field, both MSB first. If the ID mismatches, the normal 2-bit code applies.
- R9: The last 4 bits of the frame (MSB first) are compared with a check code computed over the start bit through the end of the payload. The check code uses the polynomial x^4+x^2+x+1 with an initial value of 0, and `crc_ok` reports whether they match.
- R10: `done` is a one-cycle pulse after the last check-code bit. The published outputs change only in that cycle.
- R11: `busy_count` increments (saturating) on a completed busy reply from the addressed slave. Any other completed reply from the addressed slave clears it, and `brk` clears it. A reply whose ID mismatches leaves it unchanged.
- R12: `brk` aborts any frame in progress: no `done` follows, and later slots are ignored until the next `cmd_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lnk_clk | input | 1 | Link clock, asynchronous |
| lnk_line | input | 1 | Link data line, active low, asynchronous |
| brk | input | 1 | Break detected on the link (pulse) |
| cmd_end | input | 1 | Master command frame finished (pulse) |
| cmd_slave | input | 2 | Slave addressed by the command |
| cmd_read | input | 1 | Command was a read |
| cmd_size | input | 2 | Requested data size code |
| cmd_ipoll | input | 1 | Command was an interrupt poll |
| rsp_kind | output | 3 | Decoded reply type |
| rsp_slave | output | 2 | Slave ID in the reply |
| rsp_data | output | 32 | Read data |
| irq_field | output | 2 | Interrupt field of a poll reply |
| dma_field | output | 3 | DMA control field of a poll reply |
| crc_ok | output | 1 | Check code matched |
| id_mismatch | output | 1 | Reply ID differs from addressed slave |
| done | output | 1 | Reply decoded (pulse) |
| timeout | output | 1 | No start bit within the wait window (pulse) |
| busy_count | output | 8 | Consecutive busy replies |

## Verification
A slot counter that drifts by one shifts every later field by one bit. That shows up in the same frame as a wrong `rsp_kind`, a wrong ID, corrupted `rsp_data` or a false `crc_ok` at the `done` pulse. A wrong turnaround or wait count appears either as a misparsed reply or as a `timeout` that arrives one slot early or late, which the boundary frames with a start in the last permitted slot expose. A corrupted busy tracker becomes visible at the next completed reply, where `busy_count` can be compared with the known sequence of replies.

// File: rtl/rsp_pkg.sv
// Shared types and the check-code step for the slave response decoder.
// Assumes a 4-bit check code over polynomial x^4+x^2+x+1, shifted MSB first.
package rsp_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_TAR, S_WAIT, S_ID, S_CODE, S_DATA, S_IRQ, S_DMA, S_CRC
    } rsp_state_e;

    typedef enum logic [2:0] {
        RK_NONE     = 3'd0,
        RK_ACK      = 3'd1,
        RK_ACK_DATA = 3'd2,
        RK_BUSY     = 3'd3,
        RK_ADDR_ERR = 3'd4,
        RK_CRC_ERR  = 3'd5,
        RK_IPOLL    = 3'd6
    } rsp_kind_e;

    // One Galois step of the 4-bit check code with one input bit.
    function automatic logic [3:0] crc4_step(input logic [3:0] c, input logic b);
        logic fb;
        fb = c[3] ^ b;
        return {c[2], c[1] ^ fb, c[0] ^ fb, fb};
    endfunction

endpackage

// File: rtl/rsp_line_sampler.sv
// Brings the asynchronous link clock and data line into the system clock
// domain and emits one slot strobe per falling edge of the link clock,
// with the bit value already inverted (line low means 1).
// Assumes the link clock half period spans several system clocks.
module rsp_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lnk_clk,
    input  logic lnk_line,
    output logic slot_tick,
    output logic slot_bit
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] ck_sync;
    logic [MSB:0] ln_sync;
    logic         ck_last;

    // Synchroniser chains, one flop per stage, built per stage.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage captures the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ck_sync[0] <= 1'b0;
                    ln_sync[0] <= 1'b1;
                end else begin
                    ck_sync[0] <= lnk_clk;
                    ln_sync[0] <= lnk_line;
                end
            end
        end else begin : g_next
            // Later stages follow the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ck_sync[g] <= 1'b0;
                    ln_sync[g] <= 1'b1;
                end else begin
                    ck_sync[g] <= ck_sync[g-1];
                    ln_sync[g] <= ln_sync[g-1];
                end
            end
        end
    end

    // Falling-edge detector and inverted bit capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_last   <= 1'b0;
            slot_tick <= 1'b0;
            slot_bit  <= 1'b0;
        end else begin
            ck_last   <= ck_sync[MSB];
            slot_tick <= ck_last & ~ck_sync[MSB];
            slot_bit  <= ~ln_sync[MSB];
        end
    end

    // R2: a falling edge yields a single-cycle strobe.
    p_tick_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick |=> !slot_tick);

endmodule

// File: rtl/rsp_crc4.sv
// Accumulates the 4-bit check code over the bits of a reply frame.
// Assumes clear and advance may coincide: the cleared value is then stepped.
module rsp_crc4 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       adv,
    input  logic       din,
    output logic [3:0] crc
);
    import rsp_pkg::*;

    logic [3:0] base;

    // Select the starting value for this step.
    always_comb base = clr ? 4'd0 : crc;

    // Register the running check code.
    always_ff @(posedge clk) begin
        if (!rst_n)   crc <= 4'd0;
        else if (adv) crc <= crc4_step(base, din);
        else if (clr) crc <= 4'd0;
    end

    // R9: the code is frozen when no bit is fed.
    p_crc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(crc));

endmodule

// File: rtl/rsp_busy_tracker.sv
// Counts consecutive busy replies from the addressed slave.
// Assumes upd pulses once per completed reply; brk has priority.
module rsp_busy_tracker #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic             matched,
    input  logic             is_busy,
    input  logic             brk,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Increment, clear or hold the busy run length.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else if (brk) count <= '0;
        else if (upd && matched) begin
            if (!is_busy)              count <= '0;
            else if (count != CNT_MAX) count <= count + 1'b1;
        end
    end

    p_busy_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> (count == '0));
    p_busy_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!brk && upd && matched && is_busy && count != CNT_MAX)
            |=> (count == $past(count) + 1'b1));
    p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!brk && !(upd && matched)) |=> $stable(count));

endmodule

// File: rtl/slv_rsp_decoder.sv
// Decodes the slave's reply on the serial management link after a master
// command. Counts turnaround slots, hunts for the start bit with a bounded
// wait, then parses the ID, response code, payload and check code.
// Assumes cmd_* inputs are valid in the cycle cmd_end pulses.
module slv_rsp_decoder #(
    parameter int SYNC_STAGES = 2,
    parameter int TAR_SLOTS   = 3,
    parameter int WAIT_SLOTS  = 256,
    parameter int BUSY_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lnk_clk,
    input  logic              lnk_line,
    input  logic              brk,
    input  logic              cmd_end,
    input  logic [1:0]        cmd_slave,
    input  logic              cmd_read,
    input  logic [1:0]        cmd_size,
    input  logic              cmd_ipoll,
    output logic [2:0]        rsp_kind,
    output logic [1:0]        rsp_slave,
    output logic [31:0]       rsp_data,
    output logic [1:0]        irq_field,
    output logic [2:0]        dma_field,
    output logic              crc_ok,
    output logic              id_mismatch,
    output logic              done,
    output logic              timeout,
    output logic [BUSY_W-1:0] busy_count
);
    import rsp_pkg::*;

    localparam int DATA_W = 32;
    localparam int WAIT_W = $clog2(WAIT_SLOTS);
    localparam int CW     = (WAIT_W > 5) ? WAIT_W : 5;
    localparam logic [CW-1:0] TAR_LAST  = CW'(TAR_SLOTS - 1);
    localparam logic [CW-1:0] WAIT_LAST = CW'(WAIT_SLOTS - 1);

    rsp_state_e       st;
    logic [CW-1:0]    cnt;
    logic             s_tick, s_bit;
    logic [1:0]       p_slave, p_size;
    logic             p_read, p_ipoll;
    logic [1:0]       w_id;
    logic             code0;
    rsp_kind_e        w_kind;
    logic [DATA_W-1:0] w_data;
    logic [1:0]       w_irq;
    logic [2:0]       w_dma;
    logic [2:0]       w_crc;
    logic [3:0]       crc_calc;
    logic             crc_clr, crc_adv, fin, id_hit;
    logic [CW-1:0]    len_last;

    rsp_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
        .clk(clk), .rst_n(rst_n), .lnk_clk(lnk_clk), .lnk_line(lnk_line),
        .slot_tick(s_tick), .slot_bit(s_bit)
    );

    rsp_crc4 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .adv(crc_adv),
        .din(s_bit), .crc(crc_calc)
    );

    rsp_busy_tracker #(.CNT_W(BUSY_W)) u_busy (
        .clk(clk), .rst_n(rst_n), .upd(fin), .matched(id_hit),
        .is_busy(w_kind == RK_BUSY), .brk(brk), .count(busy_count)
    );

    // Slot-level control strobes for the check code and the busy tracker.
    always_comb begin
        id_hit  = (w_id == p_slave);
        crc_clr = s_tick && !brk && !cmd_end && st == S_WAIT && s_bit;
        crc_adv = s_tick && !brk && !cmd_end &&
                  (crc_clr || st == S_ID || st == S_CODE ||
                   st == S_DATA || st == S_IRQ || st == S_DMA);
        fin     = s_tick && !brk && !cmd_end && st == S_CRC && cnt == CW'(3);
    end

    // Index of the last data bit for the latched size code.
    always_comb begin
        case (p_size)
            2'd0:    len_last = CW'(7);
            2'd1:    len_last = CW'(15);
            default: len_last = CW'(31);
        endcase
    end

    // Frame sequencer: one transition per bit slot, break and command first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= S_IDLE;
            cnt         <= '0;
            p_slave     <= '0;
            p_size      <= '0;
            p_read      <= 1'b0;
            p_ipoll     <= 1'b0;
            w_id        <= '0;
            code0       <= 1'b0;
            w_kind      <= RK_NONE;
            w_data      <= '0;
            w_irq       <= '0;
            w_dma       <= '0;
            w_crc       <= '0;
            rsp_kind    <= 3'd0;
            rsp_slave   <= '0;
            rsp_data    <= '0;
            irq_field   <= '0;
            dma_field   <= '0;
            crc_ok      <= 1'b0;
            id_mismatch <= 1'b0;
            done        <= 1'b0;
            timeout     <= 1'b0;
        end else begin
            done    <= 1'b0;
            timeout <= 1'b0;
            if (brk) begin
                st <= S_IDLE;
            end else if (cmd_end) begin
                st      <= S_TAR;
                cnt     <= '0;
                p_slave <= cmd_slave;
                p_size  <= cmd_size;
                p_read  <= cmd_read;
                p_ipoll <= cmd_ipoll;
            end else if (s_tick) begin
                case (st)
                    S_TAR: begin
                        if (cnt == TAR_LAST) begin
                            st  <= S_WAIT;
                            cnt <= '0;
                        end else cnt <= cnt + 1'b1;
                    end
                    S_WAIT: begin
                        if (s_bit) begin
                            st  <= S_ID;
                            cnt <= '0;
                        end else if (cnt == WAIT_LAST) begin
                            timeout <= 1'b1;
                            st      <= S_IDLE;
                        end else cnt <= cnt + 1'b1;
                    end
                    S_ID: begin
                        w_id <= {s_bit, w_id[1]};
                        if (cnt[0]) begin
                            st  <= S_CODE;
                            cnt <= '0;
                        end else cnt <= CW'(1);
                    end
                    S_CODE: begin
                        if (cnt == '0) begin
                            if (p_ipoll && id_hit && !s_bit) begin
                                w_kind <= RK_IPOLL;
                                st     <= S_IRQ;
                            end else begin
                                code0 <= s_bit;
                                cnt   <= CW'(1);
                            end
                        end else begin
                            cnt <= '0;
                            case ({code0, s_bit})
                                2'b00: w_kind <= p_read ? RK_ACK_DATA : RK_ACK;
                                2'b01: w_kind <= RK_BUSY;
                                2'b10: w_kind <= RK_ADDR_ERR;
                                default: w_kind <= RK_CRC_ERR;
                            endcase
                            if (!code0 && !s_bit && p_read) begin
                                w_data <= '0;
                                st     <= S_DATA;
                            end else st <= S_CRC;
                        end
                    end
                    S_DATA: begin
                        w_data <= {w_data[DATA_W-2:0], s_bit};
                        if (cnt == len_last) begin
                            st  <= S_CRC;
                            cnt <= '0;
                        end else cnt <= cnt + 1'b1;
                    end
                    S_IRQ: begin
                        w_irq <= {w_irq[0], s_bit};
                        if (cnt == CW'(1)) begin
                            st  <= S_DMA;
                            cnt <= '0;
                        end else cnt <= cnt + 1'b1;
                    end
                    S_DMA: begin
                        w_dma <= {w_dma[1:0], s_bit};
                        if (cnt == CW'(2)) begin
                            st  <= S_CRC;
                            cnt <= '0;
                        end else cnt <= cnt + 1'b1;
                    end
                    S_CRC: begin
                        w_crc <= {w_crc[1:0], s_bit};
                        if (cnt == CW'(3)) begin
                            st          <= S_IDLE;
                            done        <= 1'b1;
                            crc_ok      <= ({w_crc, s_bit} == crc_calc);
                            rsp_kind    <= w_kind;
                            rsp_slave   <= w_id;
                            id_mismatch <= !id_hit;
                            rsp_data    <= (w_kind == RK_ACK_DATA) ? w_data : '0;
                            irq_field   <= (w_kind == RK_IPOLL) ? w_irq : '0;
                            dma_field   <= (w_kind == RK_IPOLL) ? w_dma : '0;
                        end else cnt <= cnt + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: completion is a single-cycle pulse.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: published reply holds between completions.
    p_hold_outputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(rsp_kind) && $stable(rsp_data) && $stable(crc_ok)));
    // R4: a timeout never coincides with a completion and only ends a search.
    p_timeout_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));
    p_timeout_from_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> ($past(st) == S_WAIT));
    // R12: a break leaves the sequencer idle with no completion.
    p_brk_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> (st == S_IDLE && !done));
    // R6: only defined reply codes are published.
    p_kind_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_kind != 3'd7);

endmodule

// File: tb/tb_slv_rsp_decoder.sv
module tb_slv_rsp_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lnk_clk = 1'b0;
    logic        lnk_line = 1'b1;
    logic        brk = 1'b0;
    logic        cmd_end = 1'b0;
    logic [1:0]  cmd_slave = 2'd0;
    logic        cmd_read = 1'b0;
    logic [1:0]  cmd_size = 2'd0;
    logic        cmd_ipoll = 1'b0;
    logic [2:0]  rsp_kind;
    logic [1:0]  rsp_slave;
    logic [31:0] rsp_data;
    logic [1:0]  irq_field;
    logic [2:0]  dma_field;
    logic        crc_ok, id_mismatch, done, timeout;
    logic [7:0]  busy_count;

    int n_chk = 0, n_fail = 0, n_done = 0, n_to = 0;
    logic fbits [0:63];
    int   fn = 0;
    bit   finished = 1'b0;

    slv_rsp_decoder dut (
        .clk(clk), .rst_n(rst_n), .lnk_clk(lnk_clk), .lnk_line(lnk_line),
        .brk(brk), .cmd_end(cmd_end), .cmd_slave(cmd_slave),
        .cmd_read(cmd_read), .cmd_size(cmd_size), .cmd_ipoll(cmd_ipoll),
        .rsp_kind(rsp_kind), .rsp_slave(rsp_slave), .rsp_data(rsp_data),
        .irq_field(irq_field), .dma_field(dma_field), .crc_ok(crc_ok),
        .id_mismatch(id_mismatch), .done(done), .timeout(timeout),
        .busy_count(busy_count)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && done)    n_done++;
        if (rst_n && timeout) n_to++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One bit slot; the line holds the wrong level around the rising edge.
    task automatic slot(input logic b);
        lnk_clk = 1'b1; lnk_line = ~b;
        repeat (4) @(negedge clk);
        lnk_clk = 1'b0;
        repeat (2) @(negedge clk);
        lnk_line = b;
        repeat (2) @(negedge clk);
    endtask

    task automatic fclr();
        fn = 0; fbits[fn] = 1'b1; fn++;
    endtask
    task automatic fpush(input logic b);
        fbits[fn] = b; fn++;
    endtask
    task automatic fpush_msb(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) fpush(v[i]);
    endtask
    task automatic fpush_id(input logic [1:0] id);
        fpush(id[0]); fpush(id[1]);
    endtask
    task automatic fcrc(input bit good);
        logic [3:0] c = 4'd0;
        logic fb;
        for (int i = 0; i < fn; i++) begin
            fb = c[3] ^ fbits[i];
            c = {c[2], c[1] ^ fb, c[0] ^ fb, fb};
        end
        if (!good) c = ~c;
        fpush_msb({28'd0, c}, 4);
    endtask

    task automatic run_frame(input logic [1:0] sl, input logic rd, input logic [1:0] sz,
                             input logic ip, input logic [2:0] tarb, input int gap);
        cmd_slave = sl; cmd_read = rd; cmd_size = sz; cmd_ipoll = ip;
        cmd_end = 1'b1; @(negedge clk); cmd_end = 1'b0;
        for (int i = 0; i < 3; i++) slot(tarb[i]);
        for (int i = 0; i < gap; i++) slot(1'b0);
        for (int i = 0; i < fn; i++) slot(fbits[i]);
        repeat (12) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 done", done, 0); chk("R1 timeout", timeout, 0);
        chk("R1 busy", busy_count, 0); chk("R1 kind", rsp_kind, 0);
    endtask

    task automatic t_ack_write();
        int d0 = n_done;
        fclr(); fpush_id(2'd1); fpush_msb(0, 2); fcrc(1);
        run_frame(2'd1, 0, 0, 0, 3'b000, 2);
        chk("R10 done count", n_done - d0, 1);
        chk("R6 ack kind", rsp_kind, 1); chk("R9 crc ok", crc_ok, 1);
        chk("R5 slave", rsp_slave, 1); chk("R5 no mismatch", id_mismatch, 0);
        chk("R2 R7 data zero", rsp_data, 0);
    endtask

    task automatic t_read(input logic [1:0] sz, input int n, input logic [31:0] v);
        fclr(); fpush_id(2'd2); fpush_msb(0, 2); fpush_msb(v, n); fcrc(1);
        run_frame(2'd2, 1, sz, 0, 3'b000, 1);
        chk("R6 ack data kind", rsp_kind, 2);
        chk("R7 read data", rsp_data, v); chk("R9 read crc", crc_ok, 1);
    endtask

    task automatic t_code(input logic [1:0] code, input logic [1:0] sl, input logic [1:0] rid,
                          input logic [2:0] kind, input logic [7:0] busy_exp);
        fclr(); fpush_id(rid); fpush_msb({30'd0, code}, 2); fcrc(1);
        run_frame(sl, 0, 0, 0, 3'b000, 0);
        chk("R6 code kind", rsp_kind, kind);
        chk("R5 mismatch flag", id_mismatch, (rid != sl));
        chk("R11 busy count", busy_count, busy_exp);
    endtask

    task automatic t_bad_crc();
        fclr(); fpush_id(2'd0); fpush_msb(0, 2); fcrc(0);
        run_frame(2'd0, 0, 0, 0, 3'b000, 0);
        chk("R9 bad crc", crc_ok, 0);
    endtask

    task automatic t_ipoll();
        fclr(); fpush_id(2'd2); fpush(1'b0); fpush_msb(2'b10, 2); fpush_msb(3'b101, 3); fcrc(1);
        run_frame(2'd2, 0, 0, 1, 3'b000, 0);
        chk("R8 ipoll kind", rsp_kind, 6); chk("R8 irq", irq_field, 2);
        chk("R8 dma", dma_field, 5); chk("R8 crc", crc_ok, 1);
        fclr(); fpush_id(2'd1); fpush_msb(0, 2); fcrc(1);
        run_frame(2'd2, 0, 0, 1, 3'b000, 0);
        chk("R8 mismatched ipoll is ack", rsp_kind, 1);
        chk("R8 irq cleared", irq_field, 0); chk("R8 crc2", crc_ok, 1);
    endtask

    task automatic t_tar();
        fclr(); fpush_id(2'd3); fpush_msb(0, 2); fcrc(1);
        run_frame(2'd3, 0, 0, 0, 3'b111, 0);
        chk("R3 kind after busy turnaround", rsp_kind, 1);
        chk("R3 slave", rsp_slave, 3); chk("R3 crc", crc_ok, 1);
    endtask

    task automatic t_timeout();
        int d0 = n_done, t0 = n_to;
        fn = 0;
        run_frame(2'd0, 0, 0, 0, 3'b000, 256);
        chk("R4 timeout pulse", n_to - t0, 1);
        chk("R4 no done", n_done - d0, 0);
        fclr(); fpush_id(2'd0); fpush_msb(0, 2); fcrc(1);
        for (int i = 0; i < fn; i++) slot(fbits[i]);
        repeat (12) @(negedge clk);
        chk("R4 ignored after timeout", n_done - d0, 0);
        fclr(); fpush_id(2'd1); fpush_msb(2'b10, 2); fcrc(1);
        run_frame(2'd1, 0, 0, 0, 3'b000, 255);
        chk("R4 start in last slot", n_done - d0, 1);
        chk("R4 kind", rsp_kind, 4); chk("R4 no timeout", n_to - t0, 1);
    endtask

    task automatic t_break();
        int d0;
        t_code(2'b01, 2'd0, 2'd0, 3, 1);
        d0 = n_done;
        fclr(); fpush_id(2'd0); fpush_msb(2'b01, 2); fcrc(1);
        cmd_slave = 2'd0; cmd_ipoll = 0; cmd_read = 0;
        cmd_end = 1'b1; @(negedge clk); cmd_end = 1'b0;
        for (int i = 0; i < 3; i++) slot(1'b0);
        for (int i = 0; i < 4; i++) slot(fbits[i]);
        brk = 1'b1; @(negedge clk); brk = 1'b0;
        for (int i = 4; i < fn; i++) slot(fbits[i]);
        repeat (12) @(negedge clk);
        chk("R12 no done after break", n_done - d0, 0);
        chk("R11 break clears busy", busy_count, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ack_write();
        t_read(2'd0, 8, 32'h000000A5);
        t_read(2'd1, 16, 32'h00001234);
        t_read(2'd2, 32, 32'hDEADBEEF);
        t_code(2'b01, 2'd1, 2'd1, 3, 1);
        t_code(2'b01, 2'd1, 2'd1, 3, 2);
        t_code(2'b01, 2'd1, 2'd2, 3, 2);
        t_code(2'b11, 2'd1, 2'd1, 5, 0);
        t_code(2'b01, 2'd1, 2'd1, 3, 1);
        t_code(2'b10, 2'd1, 2'd1, 4, 0);
        t_bad_crc();
        t_ipoll();
        t_tar();
        t_timeout();
        t_break();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule